// File: doc/BRIEF.md
# SPI command-stream sequencer

This block runs a serial-peripheral bus master from a stream of 16-bit instruction words rather than from fixed control registers. Each word is popped from a command FIFO and decoded in one cycle. A word can start a burst of data words, load the chip-select vector, change an internal setting (clock divider, bus mode, word width), wait a timed interval, or post an 8-bit marker back to the host side. Transmit words come from an outgoing FIFO and received words go into an incoming FIFO. All three FIFOs sit outside the block. The block sees each one as a valid/ready pair, where a pop or push happens in the cycle in which both are high.

A command word is laid out as opcode `[15:12]`, first argument `[11:8]` and second argument `[7:0]`. A host builds a job as a short program. It sets the mode, width and divider, lowers a chip-select bit, issues one or more bursts, raises the chip-select again, and ends with a marker whose identifier tells the host that the whole program has run.

Top module: `spiseq_top`

## Requirements
- R1: After a synchronous reset, `cs_n` is 0xFF, `sclk` is 0, `sync_valid` is 0, `sync_id` is 0, `three_wire` is 0 and `cmd_ready` is 1. The divider resets to 0, the mode to 0 and the word width to 8.
- R2: Opcodes 0 (burst), 1 (chip-select), 2 (setting write) and 3 (miscellaneous) are decoded. Any other opcode, a setting write to an index other than 0, 1 or 2, and a miscellaneous word whose first argument is neither 0 nor 1 are all consumed and have no effect.
- R3: Opcode 1 loads its second argument into `cs_n`, and the new value is visible in the cycle after the word is accepted. `cs_n` changes at no other time.
- R4: Opcode 3 with first argument 0 raises `sync_valid` for exactly the cycle after acceptance. `sync_id` takes the second argument at that edge and keeps it until the next marker.
- R5: Opcode 3 with first argument 1 and second argument N blocks fetching for 2·(N+1)·(D+1) cycles, where D is the current divider. Two markers that surround such a wait therefore pulse 2·(N+1)·(D+1)+2 cycles apart.
- R6: Opcode 2 with index 0 sets the divider D. Each `sclk` half-period lasts D+1 clock cycles, so D=0 gives half the clock rate.
- R7: Opcode 0 moves (second argument + 1) words of the current width, most significant bit first. First-argument bit 0 pops one outgoing word per bus word and shifts it out; otherwise zeros are sent. Bit 1 pushes one right-aligned incoming word per bus word. Each word takes exactly 2·width `sclk` transitions.
- R8: Opcode 2 with index 2 sets the width to a value from 1 to 32. A value of 0 or above 32 is ignored. Outgoing bits above the width are never sent.
- R9: Opcode 2 with index 1 sets the mode: bit 0 is CPHA, bit 1 is CPOL and bit 2 is three-wire. `sclk` idles at CPOL. With CPHA=0 data is sampled on the leading edge and changed on the trailing edge; with CPHA=1 the roles swap. `sdo` looped back to `sdi` returns every word intact in all four modes.
- R10: The block stalls, with no `sclk` transition and no loss of state, while the command FIFO is empty, while the outgoing FIFO is empty before a write word, or while the incoming FIFO is full before a read word. It never pops an empty FIFO or pushes a full one.
- R11: `three_wire` follows mode bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command FIFO holds a word |
| cmd_data | input | 16 | Command word at the FIFO head |
| cmd_ready | output | 1 | Command word consumed this cycle when valid |
| sdo_valid | input | 1 | Outgoing FIFO holds a word |
| sdo_data | input | DW | Outgoing word at the FIFO head |
| sdo_ready | output | 1 | Outgoing word popped this cycle |
| sdi_valid | output | 1 | Incoming word pushed this cycle |
| sdi_data | output | DW | Received word, right-aligned |
| sdi_ready | input | 1 | Incoming FIFO has room |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| cs_n | output | NCS | Active-low chip selects |
| three_wire | output | 1 | Three-wire bus mode enable |
| sync_valid | output | 1 | One-cycle marker strobe |
| sync_id | output | 8 | Identifier of the last marker |

## Verification
The embedded properties check on every cycle that the FIFO handshakes never pop an empty source or push a full sink, that `cs_n` moves only after a chip-select word, that every marker strobe follows the acceptance of a marker word, that divider ticks respect the programmed spacing, and that `sclk` sits at its idle level between bursts. Only the directed scenarios can show data integrity: the loopback contents in each CPOL/CPHA mode, width truncation and the rejection of illegal widths, the exact sleep length measured between marker pulses, the transition count per burst, and the absence of bus activity during a stall followed by correct completion.

// File: rtl/spiseq_pkg.sv
package spiseq_pkg;
  localparam logic [3:0] OP_XFER  = 4'd0;
  localparam logic [3:0] OP_CS    = 4'd1;
  localparam logic [3:0] OP_WRREG = 4'd2;
  localparam logic [3:0] OP_MISC  = 4'd3;

  localparam logic [3:0] REG_DIV   = 4'd0;
  localparam logic [3:0] REG_MODE  = 4'd1;
  localparam logic [3:0] REG_WIDTH = 4'd2;

  localparam logic [3:0] MISC_SYNC  = 4'd0;
  localparam logic [3:0] MISC_SLEEP = 4'd1;

  typedef struct packed {
    logic [3:0] op;
    logic [3:0] a1;
    logic [7:0] a2;
  } cmd_t;

  typedef enum logic [1:0] {SQ_FETCH, SQ_XFER, SQ_SLEEP} seq_state_e;
  typedef enum logic [1:0] {SH_IDLE, SH_LOAD, SH_BITS} shift_state_e;
endpackage

// File: rtl/spiseq_tick.sv
module spiseq_tick #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [DIVW-1:0] div,
  output logic            tick
);
  logic [DIVW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)   cnt <= '0;
    else if (cnt == div) cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == div);

  // R6
  tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && div != '0 && $stable(div)) |=> !tick);
endmodule

// File: rtl/spiseq_shift.sv
module spiseq_shift
  import spiseq_pkg::*;
#(
  parameter int DW   = 32,
  parameter int CNTW = 8,
  parameter int BW   = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [CNTW-1:0] count,
  input  logic [BW-1:0]   bits,
  input  logic            cpol,
  input  logic            cpha,
  input  logic            tick,
  output logic            run,
  output logic            busy,
  output logic            sclk,
  output logic            sdo,
  input  logic            sdi,
  input  logic [DW-1:0]   sdo_data,
  input  logic            sdo_valid,
  output logic            sdo_ready,
  output logic [DW-1:0]   sdi_data,
  output logic            sdi_valid,
  input  logic            sdi_ready
);
  localparam int EW = BW + 1;

  shift_state_e    st;
  logic            wr_q, rd_q, sclk_q, sdo_q;
  logic [CNTW-1:0] left;
  logic [EW-1:0]   edge_cnt;
  logic [DW-1:0]   tx_sh, rx_sh, word_in, aligned, rx_next;
  logic            can_go, last_edge, sample_now, shift_now;

  assign can_go     = (!wr_q || sdo_valid) && (!rd_q || sdi_ready);
  assign word_in    = wr_q ? sdo_data : '0;
  assign aligned    = word_in << (EW'(DW) - EW'(bits));
  assign last_edge  = edge_cnt == ({bits, 1'b0} - EW'(1));
  assign sample_now = tick && (edge_cnt[0] == cpha);
  assign shift_now  = tick && (edge_cnt[0] != cpha);
  assign rx_next    = {rx_sh[DW-2:0], sdi};

  assign run       = (st == SH_BITS);
  assign busy      = (st != SH_IDLE);
  assign sdo_ready = (st == SH_LOAD) && can_go && wr_q;
  assign sdi_valid = (st == SH_BITS) && tick && last_edge && rd_q;
  assign sdi_data  = cpha ? rx_next : rx_sh;
  assign sclk      = sclk_q;
  assign sdo       = sdo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= SH_IDLE; wr_q <= 1'b0; rd_q <= 1'b0; left <= '0;
      edge_cnt <= '0; tx_sh <= '0; rx_sh <= '0; sclk_q <= 1'b0; sdo_q <= 1'b0;
    end else begin
      case (st)
        SH_IDLE: begin
          sclk_q <= cpol;
          if (start) begin
            wr_q <= wr_en; rd_q <= rd_en; left <= count; st <= SH_LOAD;
          end
        end
        SH_LOAD: begin
          sclk_q <= cpol;
          if (can_go) begin
            rx_sh    <= '0;
            edge_cnt <= '0;
            st       <= SH_BITS;
            if (cpha) tx_sh <= aligned;
            else begin
              sdo_q <= aligned[DW-1];
              tx_sh <= aligned << 1;
            end
          end
        end
        default: begin
          if (tick) begin
            sclk_q   <= ~sclk_q;
            edge_cnt <= edge_cnt + 1'b1;
            if (shift_now) begin
              sdo_q <= tx_sh[DW-1];
              tx_sh <= tx_sh << 1;
            end
            if (sample_now) rx_sh <= rx_next;
            if (last_edge) begin
              if (left == '0) st <= SH_IDLE;
              else begin
                left <= left - 1'b1;
                st   <= SH_LOAD;
              end
            end
          end
        end
      endcase
    end
  end

  // R10
  sdo_pop_chk: assert property (@(posedge clk) disable iff (rst)
    sdo_ready |-> sdo_valid);
  // R10
  sdi_push_chk: assert property (@(posedge clk) disable iff (rst)
    sdi_valid |-> sdi_ready);
  // R9
  sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (st == SH_IDLE && $past(st == SH_IDLE) && $stable(cpol)) |-> sclk_q == cpol);
endmodule

// File: rtl/spiseq_top.sv
module spiseq_top
  import spiseq_pkg::*;
#(
  parameter int DW   = 32,
  parameter int DIVW = 8,
  parameter int NCS  = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cmd_valid,
  input  logic [15:0]    cmd_data,
  output logic           cmd_ready,
  input  logic           sdo_valid,
  input  logic [DW-1:0]  sdo_data,
  output logic           sdo_ready,
  output logic           sdi_valid,
  output logic [DW-1:0]  sdi_data,
  input  logic           sdi_ready,
  output logic           sclk,
  output logic           sdo,
  input  logic           sdi,
  output logic [NCS-1:0] cs_n,
  output logic           three_wire,
  output logic           sync_valid,
  output logic [7:0]     sync_id
);
  localparam int BW = $clog2(DW) + 1;

  seq_state_e     seq_st;
  cmd_t           c;
  logic           fire, tick, sh_run, sh_busy, start;
  logic [DIVW-1:0] div_q;
  logic [2:0]     mode_q;
  logic [BW-1:0]  bits_q;
  logic [NCS-1:0] cs_q;
  logic           sync_v;
  logic [7:0]     sync_id_q;
  logic [8:0]     sleep_left;

  assign c          = cmd_t'(cmd_data);
  assign cmd_ready  = (seq_st == SQ_FETCH);
  assign fire       = cmd_valid && cmd_ready;
  assign start      = fire && (c.op == OP_XFER);
  assign cs_n       = cs_q;
  assign three_wire = mode_q[2];
  assign sync_valid = sync_v;
  assign sync_id    = sync_id_q;

  spiseq_tick #(.DIVW(DIVW)) u_tick (
    .clk(clk), .rst(rst), .run(sh_run || seq_st == SQ_SLEEP),
    .div(div_q), .tick(tick)
  );

  spiseq_shift #(.DW(DW), .CNTW(8), .BW(BW)) u_shift (
    .clk(clk), .rst(rst), .start(start), .wr_en(c.a1[0]), .rd_en(c.a1[1]),
    .count(c.a2), .bits(bits_q), .cpol(mode_q[1]), .cpha(mode_q[0]),
    .tick(tick), .run(sh_run), .busy(sh_busy), .sclk(sclk), .sdo(sdo),
    .sdi(sdi), .sdo_data(sdo_data), .sdo_valid(sdo_valid), .sdo_ready(sdo_ready),
    .sdi_data(sdi_data), .sdi_valid(sdi_valid), .sdi_ready(sdi_ready)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      seq_st <= SQ_FETCH; div_q <= '0; mode_q <= '0; bits_q <= BW'(8);
      cs_q <= '1; sync_v <= 1'b0; sync_id_q <= '0; sleep_left <= '0;
    end else begin
      sync_v <= 1'b0;
      case (seq_st)
        SQ_FETCH: if (fire) begin
          case (c.op)
            OP_XFER: seq_st <= SQ_XFER;
            OP_CS:   cs_q <= c.a2[NCS-1:0];
            OP_WRREG: begin
              case (c.a1)
                REG_DIV:   div_q  <= c.a2[DIVW-1:0];
                REG_MODE:  mode_q <= c.a2[2:0];
                REG_WIDTH: if (c.a2 != 8'd0 && int'(c.a2) <= DW) bits_q <= c.a2[BW-1:0];
                default: ;
              endcase
            end
            OP_MISC: begin
              if (c.a1 == MISC_SYNC) begin
                sync_v    <= 1'b1;
                sync_id_q <= c.a2;
              end else if (c.a1 == MISC_SLEEP) begin
                sleep_left <= {c.a2, 1'b1};
                seq_st     <= SQ_SLEEP;
              end
            end
            default: ;
          endcase
        end
        SQ_XFER: if (!sh_busy) seq_st <= SQ_FETCH;
        default: if (tick) begin
          if (sleep_left == '0) seq_st <= SQ_FETCH;
          else sleep_left <= sleep_left - 1'b1;
        end
      endcase
    end
  end

  // R4
  sync_src_chk: assert property (@(posedge clk) disable iff (rst)
    sync_valid |-> $past(cmd_valid && cmd_ready && cmd_data[15:12] == OP_MISC
                         && cmd_data[11:8] == MISC_SYNC));
  // R3
  cs_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(cmd_valid && cmd_ready && cmd_data[15:12] == OP_CS) |=> $stable(cs_n));
endmodule

// File: tb/spiseq_top_test.sv
module spiseq_top_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic        cmd_valid, cmd_ready, sdo_valid, sdo_ready, sdi_valid, sdi_ready;
  logic [15:0] cmd_data;
  logic [31:0] sdo_data, sdi_data;
  logic        sclk, sdo, sdi, three_wire, sync_valid;
  logic [7:0]  cs_n, sync_id;

  logic [15:0] cq [0:255];
  logic [31:0] dq [0:255];
  logic [31:0] rxq [0:255];
  logic [7:0]  ch = 0, ct = 0, dh = 0, dt = 0, rxn = 0;
  logic        sdo_hold = 0, sdi_block = 0, lb = 1, sdi_const = 0;
  int          nchk = 0, nfail = 0;
  int          cyc = 0, sync_cnt = 0, last_sync = 0, prev_sync = 0;
  int          toggles = 0, last_tog = 0, gap = 0;
  logic        sclk_d = 0;

  assign cmd_valid = (ch != ct);
  assign cmd_data  = cq[ch];
  assign sdo_valid = (dh != dt) && !sdo_hold;
  assign sdo_data  = dq[dh];
  assign sdi_ready = !sdi_block;
  assign sdi       = lb ? sdo : sdi_const;

  spiseq_top uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
    .cmd_ready(cmd_ready), .sdo_valid(sdo_valid), .sdo_data(sdo_data),
    .sdo_ready(sdo_ready), .sdi_valid(sdi_valid), .sdi_data(sdi_data),
    .sdi_ready(sdi_ready), .sclk(sclk), .sdo(sdo), .sdi(sdi), .cs_n(cs_n),
    .three_wire(three_wire), .sync_valid(sync_valid), .sync_id(sync_id)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      ch <= 0; dh <= 0; rxn <= 0; sclk_d <= 0;
    end else begin
      if (cmd_valid && cmd_ready) ch <= ch + 1;
      if (sdo_ready && sdo_valid) dh <= dh + 1;
      if (sdi_valid && sdi_ready) begin
        rxq[rxn] <= sdi_data;
        rxn <= rxn + 1;
      end
      if (sync_valid) begin
        sync_cnt <= sync_cnt + 1;
        prev_sync <= last_sync;
        last_sync <= cyc;
      end
      sclk_d <= sclk;
      if (sclk != sclk_d) begin
        toggles <= toggles + 1;
        gap <= cyc - last_tog;
        last_tog <= cyc;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic push_cmd(input logic [3:0] op, input logic [3:0] a1, input logic [7:0] a2);
    @(negedge clk);
    cq[ct] = {op, a1, a2};
    ct = ct + 1;
  endtask

  task automatic push_sdo(input logic [31:0] w);
    dq[dt] = w;
    dt = dt + 1;
  endtask

  task automatic fence(input logic [7:0] id);
    int s0;
    s0 = sync_cnt;
    push_cmd(4'd3, 4'd0, id);
    for (int i = 0; i < 20000 && sync_cnt == s0; i++) @(negedge clk);
    check(sync_cnt == s0 + 1, "R4", "fence marker", sync_cnt - s0, 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(cs_n == 8'hFF, "R1", "cs_n", cs_n, 8'hFF);
    check(sclk == 1'b0, "R1", "sclk", sclk, 0);
    check(sync_valid == 1'b0 && sync_id == 8'h00, "R1", "sync", {sync_valid, sync_id}, 0);
    check(cmd_ready == 1'b1 && three_wire == 1'b0, "R1", "ready/3w", {cmd_ready, three_wire}, 2);
  endtask

  task automatic t_cs();
    logic [7:0] r0, p0;
    push_cmd(4'd1, 4'd0, 8'hA5);
    check(cs_n == 8'hFF, "R3", "cs before accept", cs_n, 8'hFF);
    @(negedge clk);
    check(cs_n == 8'hA5, "R3", "cs after accept", cs_n, 8'hA5);
    r0 = rxn; p0 = dh;
    push_cmd(4'd5, 4'd1, 8'h00);
    push_cmd(4'd3, 4'd2, 8'h00);
    push_cmd(4'd2, 4'd7, 8'h00);
    fence(8'h01);
    check(cs_n == 8'hA5, "R2", "unknown op leaves cs", cs_n, 8'hA5);
    check(rxn == r0 && dh == p0, "R2", "unknown op moves no data", rxn - r0, 0);
    push_cmd(4'd1, 4'd0, 8'hFF);
    fence(8'h02);
    check(cs_n == 8'hFF, "R3", "cs released", cs_n, 8'hFF);
  endtask

  task automatic t_sync();
    push_cmd(4'd3, 4'd0, 8'h3C);
    @(negedge clk);
    check(sync_valid == 1'b1 && sync_id == 8'h3C, "R4", "pulse", {sync_valid, sync_id}, 9'h13C);
    @(negedge clk);
    check(sync_valid == 1'b0, "R4", "one cycle", sync_valid, 0);
    repeat (4) @(negedge clk);
    check(sync_id == 8'h3C, "R4", "id held", sync_id, 8'h3C);
  endtask

  task automatic t_sleep(input int d, input int n);
    int s0, exp;
    push_cmd(4'd2, 4'd0, 8'(d));
    fence(8'h10);
    s0 = sync_cnt;
    push_cmd(4'd3, 4'd0, 8'h11);
    push_cmd(4'd3, 4'd1, 8'(n));
    push_cmd(4'd3, 4'd0, 8'h22);
    for (int i = 0; i < 20000 && sync_cnt < s0 + 2; i++) @(negedge clk);
    exp = 2 * (n + 1) * (d + 1) + 2;
    check(last_sync - prev_sync == exp, "R5", "sleep gap", last_sync - prev_sync, exp);
  endtask

  task automatic setup(input int width, input int mode, input int d);
    push_cmd(4'd2, 4'd2, 8'(width));
    push_cmd(4'd2, 4'd1, 8'(mode));
    push_cmd(4'd2, 4'd0, 8'(d));
    fence(8'h30);
  endtask

  task automatic t_xfer();
    int t0; logic [7:0] r0, p0;
    setup(8, 0, 2);
    t0 = toggles; r0 = rxn; p0 = dh;
    push_sdo(32'hA5); push_sdo(32'h3C);
    push_cmd(4'd0, 4'd3, 8'd1);
    fence(8'h31);
    check(rxn - r0 == 2, "R7", "word count", rxn - r0, 2);
    check(rxq[r0] == 32'hA5, "R7", "word 0", rxq[r0], 32'hA5);
    check(rxq[r0 + 1] == 32'h3C, "R7", "word 1", rxq[r0 + 1], 32'h3C);
    check(toggles - t0 == 32, "R7", "transitions", toggles - t0, 32);
    check(dh - p0 == 2, "R7", "pops", dh - p0, 2);
    check(gap == 3, "R6", "half period", gap, 3);
    setup(8, 0, 0);
    push_sdo(32'h81);
    push_cmd(4'd0, 4'd3, 8'd0);
    fence(8'h32);
    check(gap == 1, "R6", "fastest half period", gap, 1);
  endtask

  task automatic width_case(input logic [31:0] w, input int bits, input logic [31:0] exp);
    int t0; logic [7:0] r0;
    t0 = toggles; r0 = rxn;
    push_sdo(w);
    push_cmd(4'd0, 4'd3, 8'd0);
    fence(8'h40);
    check(rxq[r0] == exp, "R8", "width data", rxq[r0], exp);
    check(toggles - t0 == 2 * bits, "R8", "width transitions", toggles - t0, 2 * bits);
  endtask

  task automatic t_width();
    setup(12, 0, 1);
    width_case(32'hFFFF_FABC, 12, 32'h0000_0ABC);
    push_cmd(4'd2, 4'd2, 8'd0);
    push_cmd(4'd2, 4'd2, 8'd40);
    width_case(32'h0000_0123, 12, 32'h0000_0123);
    push_cmd(4'd2, 4'd2, 8'd32);
    width_case(32'hDEAD_BEEF, 32, 32'hDEAD_BEEF);
    push_cmd(4'd2, 4'd2, 8'd1);
    width_case(32'h0000_0003, 1, 32'h0000_0001);
  endtask

  task automatic t_modes();
    for (int m = 0; m < 4; m++) begin
      logic [7:0] r0;
      logic [31:0] w;
      setup(8, m, 1);
      check(sclk == m[1], "R9", "idle level", sclk, m[1]);
      r0 = rxn;
      w = 32'h96 ^ 32'(m * 8'h11);
      push_sdo(w);
      push_cmd(4'd0, 4'd3, 8'd0);
      fence(8'h50);
      check(rxq[r0] == w, "R9", "loopback", rxq[r0], w);
      check(sclk == m[1], "R9", "idle after", sclk, m[1]);
    end
    setup(8, 0, 1);
  endtask

  task automatic t_one_way();
    int t0; logic [7:0] r0, p0;
    lb = 0; sdi_const = 1;
    setup(5, 0, 0);
    r0 = rxn; p0 = dh;
    push_cmd(4'd0, 4'd2, 8'd2);
    fence(8'h60);
    check(rxn - r0 == 3 && rxq[r0 + 2] == 32'h1F, "R7", "read only", rxq[r0 + 2], 32'h1F);
    check(dh == p0, "R7", "read only pops", dh - p0, 0);
    lb = 1;
    setup(8, 0, 0);
    t0 = toggles; r0 = rxn; p0 = dh;
    push_sdo(32'h11); push_sdo(32'h22);
    push_cmd(4'd0, 4'd1, 8'd1);
    fence(8'h61);
    check(rxn == r0 && dh - p0 == 2, "R7", "write only", rxn - r0, 0);
    check(toggles - t0 == 32, "R7", "write only transitions", toggles - t0, 32);
  endtask

  task automatic t_stall();
    int t0; logic [7:0] r0, p0;
    setup(8, 0, 0);
    sdo_hold = 1;
    t0 = toggles; r0 = rxn; p0 = dh;
    push_sdo(32'h5A);
    push_cmd(4'd0, 4'd3, 8'd0);
    repeat (40) @(negedge clk);
    check(toggles == t0 && dh == p0, "R10", "sdo empty stall", toggles - t0, 0);
    sdo_hold = 0;
    fence(8'h70);
    check(rxq[r0] == 32'h5A, "R10", "after sdo stall", rxq[r0], 32'h5A);
    sdi_block = 1;
    t0 = toggles; r0 = rxn;
    push_sdo(32'h77);
    push_cmd(4'd0, 4'd3, 8'd0);
    repeat (40) @(negedge clk);
    check(toggles == t0 && rxn == r0, "R10", "sdi full stall", toggles - t0, 0);
    sdi_block = 0;
    fence(8'h71);
    check(rxq[r0] == 32'h77, "R10", "after sdi stall", rxq[r0], 32'h77);
  endtask

  task automatic t_three();
    setup(8, 4, 0);
    check(three_wire == 1'b1, "R11", "on", three_wire, 1);
    setup(8, 0, 0);
    check(three_wire == 1'b0, "R11", "off", three_wire, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    t_reset();
    t_cs();
    t_sync();
    t_sleep(1, 3);
    t_sleep(0, 0);
    t_sleep(3, 2);
    t_xfer();
    t_width();
    t_modes();
    t_one_way();
    t_stall();
    t_three();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual 0x%0h expected 0x%0h", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule